// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the read path of a flash array. While an embedded program or sector erase is running, or while an erase is suspended and the addressed sector is one of those chosen for erase, a read returns a status byte instead of array contents. The status byte carries a data-polling bit, two toggle bits and an erase-timer bit. In every other situation the array word passes straight through to the read port.

The command interpreter drives the state inputs: operation in progress, erase versus program, erase suspended, sector-load window open, and whether the addressed sector is in the erase set. It also supplies the byte being programmed and a one-cycle pulse for each read. Bit 6 advances on every read while the operation runs. Bit 2 advances only on reads of sectors chosen for erase, and it keeps advancing while the erase is suspended. Host software compares two reads to tell an active erase from a suspended one.

Top module: `flash_status_gen`

## Requirements
- R1: With `op_busy`=0 and `erase_susp`=0, `rd_data` equals `array_data`, and reads in this state do not advance either toggle bit.
- R2: During an embedded program (`op_busy`=1, `op_erase`=0), bit 7 of `rd_data` is the inverse of bit 7 of `prog_data`.
- R3: Bit 7 reads 0 during an active erase (`op_busy`=1, `op_erase`=1) and reads 1 in a suspended-status read (`op_busy`=0, `erase_susp`=1, `sect_sel`=1).
- R4: While `op_busy`=1, each read pulse inverts bit 6 as seen by the next read. Bit 6 reads the same value in the cycle of the pulse as it did before that pulse.
- R5: In a suspended-status read, bit 6 is shown but does not change from one read to the next.
- R6: Bit 2 inverts after each read with `sect_sel`=1, both during an active erase and while suspended with `op_busy`=0.
- R7: Bit 2 holds its value after reads with `sect_sel`=0 and after reads during a program.
- R8: During an active erase, bit 3 is 0 while `win_open`=1 and 1 while `win_open`=0. Bit 3 is 0 during a program and 1 in a suspended-status read.
- R9: With `op_busy`=0, `erase_susp`=1 and `sect_sel`=0, `rd_data` equals `array_data`.
- R10: After reset both toggle bits read 0 on the first status read.
- R11: In any status byte, bits 5, 4, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_busy | input | 1 | Embedded program or erase in progress |
| op_erase | input | 1 | The running or suspended operation is an erase |
| erase_susp | input | 1 | An erase is suspended |
| win_open | input | 1 | Sector-address load window still open |
| sect_sel | input | 1 | Addressed sector is in the erase set |
| rd_pulse | input | 1 | One-cycle pulse per read access |
| prog_data | input | DATA_W | Byte being programmed |
| array_data | input | DATA_W | Word read from the array |
| rd_data | output | DATA_W | Read data: status byte or array word |

## Verification
The hardest case to reach is a long mixed read sequence. It starts with erase reads on selected and unselected sectors, then enters suspend and makes selected and unselected reads, then resumes. Across all of it, bit 2 must keep its phase while bit 6 freezes and then resumes. The stimulus builds this with a per-read task and a bench-side pair of expected toggle phases. The phases advance only by the rules in R4 through R7, so a missed or extra toggle in any state shows up on a later read.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_PROG  = 2'd1,
    RD_ERASE = 2'd2,
    RD_SUSP  = 2'd3
  } rd_src_e;

  localparam int unsigned POLL_BIT  = 7;
  localparam int unsigned TOGA_BIT  = 6;
  localparam int unsigned TIMER_BIT = 3;
  localparam int unsigned TOGS_BIT  = 2;
  localparam int unsigned NUM_TOG   = 2;
  localparam int unsigned TOG_ALL   = 0;
  localparam int unsigned TOG_SEL   = 1;
endpackage

// File: rtl/fsg_src_decode.sv
module fsg_src_decode
  import flash_status_pkg::*;
(
  input  logic                 op_busy,
  input  logic                 op_erase,
  input  logic                 erase_susp,
  input  logic                 sect_sel,
  input  logic                 rd_pulse,
  output rd_src_e              src,
  output logic [NUM_TOG-1:0]   adv
);
  always_comb begin
    src = RD_ARRAY;
    if (op_busy) begin
      src = op_erase ? RD_ERASE : RD_PROG;
    end else if (erase_susp && sect_sel) begin
      src = RD_SUSP;
    end
  end

  always_comb begin
    adv          = '0;
    adv[TOG_ALL] = rd_pulse && op_busy;
    adv[TOG_SEL] = rd_pulse && sect_sel &&
                   ((op_busy && op_erase) || (!op_busy && erase_susp));
  end
endmodule

// File: rtl/fsg_toggle_bank.sv
module fsg_toggle_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] adv,
  output logic [N-1:0] tog
);
  for (genvar g = 0; g < N; g++) begin : g_tog
    logic tog_q;
    logic tog_d;

    always_comb begin
      tog_d = tog_q;
      if (adv[g]) begin
        tog_d = ~tog_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tog_q <= 1'b0;
      end else if (adv[g]) begin
        tog_q <= tog_d;
      end
    end

    assign tog[g] = tog_q;
  end
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  rd_src_e              src,
  input  logic [NUM_TOG-1:0]   tog,
  input  logic                 win_open,
  input  logic [DATA_W-1:0]    prog_data,
  input  logic [DATA_W-1:0]    array_data,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] stat;

  always_comb begin
    stat            = '0;
    stat[TOGA_BIT]  = tog[TOG_ALL];
    stat[TOGS_BIT]  = tog[TOG_SEL];
    unique case (src)
      RD_PROG: begin
        stat[POLL_BIT]  = ~prog_data[POLL_BIT];
        stat[TIMER_BIT] = 1'b0;
      end
      RD_ERASE: begin
        stat[POLL_BIT]  = 1'b0;
        stat[TIMER_BIT] = ~win_open;
      end
      RD_SUSP: begin
        stat[POLL_BIT]  = 1'b1;
        stat[TIMER_BIT] = 1'b1;
      end
      default: begin
        stat = '0;
      end
    endcase
  end

  always_comb begin
    rd_data = (src == RD_ARRAY) ? array_data : stat;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_busy,
  input  logic              op_erase,
  input  logic              erase_susp,
  input  logic              win_open,
  input  logic              sect_sel,
  input  logic              rd_pulse,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  rd_src_e            src;
  logic [NUM_TOG-1:0] adv;
  logic [NUM_TOG-1:0] tog;

  fsg_src_decode u_dec (
    .op_busy    (op_busy),
    .op_erase   (op_erase),
    .erase_susp (erase_susp),
    .sect_sel   (sect_sel),
    .rd_pulse   (rd_pulse),
    .src        (src),
    .adv        (adv)
  );

  fsg_toggle_bank #(.N(NUM_TOG)) u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .tog   (tog)
  );

  fsg_status_mux #(.DATA_W(DATA_W)) u_mux (
    .src        (src),
    .tog        (tog),
    .win_open   (win_open),
    .prog_data  (prog_data),
    .array_data (array_data),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_busy,
  input logic              op_erase,
  input logic              erase_susp,
  input logic              sect_sel,
  input logic              rd_pulse,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_TOG-1:0] tog
);
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && !erase_susp) |-> rd_data == array_data); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && !erase_susp) |=> $stable(tog)); // R1
  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && op_erase) |-> !rd_data[POLL_BIT]); // R3
  AST_ACTIVE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && rd_pulse) |=> tog[TOG_ALL] != $past(tog[TOG_ALL])); // R4
  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && erase_susp) |=> $stable(tog[TOG_ALL])); // R5
  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && sect_sel && ((op_busy && op_erase) || (!op_busy && erase_susp)))
      |=> tog[TOG_SEL] != $past(tog[TOG_SEL])); // R6
  AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sect_sel) |=> $stable(tog[TOG_SEL])); // R7
  AST_SUSP_UNSEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && erase_susp && !sect_sel) |-> rd_data == array_data); // R9
endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_busy    (op_busy),
  .op_erase   (op_erase),
  .erase_susp (erase_susp),
  .sect_sel   (sect_sel),
  .rd_pulse   (rd_pulse),
  .array_data (array_data),
  .rd_data    (rd_data),
  .tog        (tog)
);

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          op_busy, op_erase, erase_susp, win_open, sect_sel, rd_pulse;
  logic [DW-1:0] prog_data, array_data, rd_data;

  int checks = 0;
  int fails  = 0;
  bit e6 = 1'b0;
  bit e2 = 1'b0;
  bit done = 1'b0;

  flash_status_gen #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .erase_susp(erase_susp), .win_open(win_open), .sect_sel(sect_sel),
    .rd_pulse(rd_pulse), .prog_data(prog_data), .array_data(array_data),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Expected byte from the requirements, before the toggle advance of this read.
  function automatic logic [DW-1:0] model();
    logic [DW-1:0] s;
    s = '0;
    if (op_busy) begin
      s[6] = e6; s[2] = e2;
      if (op_erase) begin s[7] = 1'b0; s[3] = ~win_open; end
      else          begin s[7] = ~prog_data[7]; s[3] = 1'b0; end
      return s;
    end
    if (erase_susp && sect_sel) begin
      s[7] = 1'b1; s[6] = e6; s[3] = 1'b1; s[2] = e2;
      return s;
    end
    return array_data;
  endfunction

  task automatic set_state(input logic b, input logic e, input logic s,
                           input logic w, input logic sel);
    @(negedge clk);
    op_busy = b; op_erase = e; erase_susp = s; win_open = w; sect_sel = sel;
  endtask

  task automatic do_read(input string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    rd_pulse = 1'b1;
    #1;
    exp = model();
    check(req, rd_data, exp);
    if (op_busy) e6 = ~e6;
    if (sect_sel && ((op_busy && op_erase) || (!op_busy && erase_susp))) e2 = ~e2;
    @(negedge clk);
    rd_pulse = 1'b0;
  endtask

  task automatic t_reset();
    set_state(1, 1, 0, 1, 1);
    #1;
    check("R10 reset bit6/bit2", rd_data & 8'h44, 8'h00);
    check("R11 unused bits zero", rd_data & 8'h33, 8'h00);
  endtask

  task automatic t_idle();
    set_state(0, 0, 0, 0, 1);
    array_data = 8'hA5; #1;
    check("R1 idle pass", rd_data, 8'hA5);
    array_data = 8'h3C;
    do_read("R1 idle read");
    do_read("R1 idle read 2");
  endtask

  task automatic t_program();
    set_state(1, 0, 0, 0, 1);
    prog_data = 8'h80; array_data = 8'hFF;
    do_read("R2 program poll inverted");
    prog_data = 8'h7F;
    do_read("R4 R7 program toggle");
    do_read("R8 program timer low");
  endtask

  task automatic t_erase();
    set_state(1, 1, 0, 1, 1);
    do_read("R8 window open");
    set_state(1, 1, 0, 0, 1);
    do_read("R3 R6 erase selected");
    set_state(1, 1, 0, 0, 0);
    do_read("R7 erase unselected");
    set_state(1, 1, 0, 0, 1);
    do_read("R4 R6 erase selected again");
  endtask

  task automatic t_suspend();
    set_state(0, 1, 1, 0, 1);
    do_read("R3 R5 suspended selected");
    do_read("R5 R6 suspended selected 2");
    set_state(0, 1, 1, 0, 0);
    array_data = 8'h5A;
    do_read("R9 suspended unselected");
    set_state(0, 1, 1, 0, 1);
    do_read("R5 R7 after unselected");
    set_state(1, 1, 0, 0, 1);
    do_read("R4 resumed erase");
  endtask

  task automatic t_done();
    set_state(0, 0, 0, 0, 0);
    array_data = 8'h81; #1;
    check("R1 back to array", rd_data, 8'h81);
    set_state(1, 1, 0, 0, 1);
    do_read("R11 R4 phase kept over idle");
  endtask

  initial begin
    rst_n = 1'b0; op_busy = 0; op_erase = 0; erase_susp = 0; win_open = 0;
    sect_sel = 0; rd_pulse = 0; prog_data = '0; array_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_program();
    t_erase();
    t_suspend();
    t_done();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule